// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block holds a small buffer of pending DRAM requests and, each cycle, grants at most one of them to the command stage. Each buffered request records whether it is a read or a write, its bank, its row, a QoS level and how many cycles it has waited. The block keeps its own record of the open row in every bank. A request whose row matches that record is a row hit, and row hits are served ahead of older misses so that fewer activate and precharge pairs are needed.

Reordering for row hits is bounded. A request whose wait reaches a runtime-programmable age cap is served before any other. A higher QoS level beats a row hit. An external per-bank ready vector, produced by the timing counters, keeps any request to a bank whose timing window is still open out of the running. After each grant the bank record is updated under the selected page policy. In open-page mode the row stays recorded as open. In closed-page mode the grant carries an auto-precharge flag and the bank is recorded as closed.

The grant is combinational from the buffer state and the ready vector. The granted slot is freed on the same clock edge, and a new request may fill a different free slot on that edge.

Top module: `fr_sched`

## Requirements
- R1: Only a valid entry whose bank has its `bank_ready` bit set can be granted. When no entry qualifies, `gnt_valid` is 0 and `gnt_slot` is all zeros.
- R2: At equal QoS level, with neither entry at the age cap, a row hit is granted before a row miss, even when the miss is older.
- R3: Among candidates with equal cap status, QoS and hit status, the one with the greater age wins. If the ages are also equal, the lowest slot index wins.
- R4: Below the age cap, a higher QoS level (larger `in_qos` value) wins over a row hit with a lower level.
- R5: An entry whose age is greater than or equal to the age cap wins over every entry below the cap, whatever their QoS level or hit status.
- R6: An entry's age is 0 in the cycle after it is written. It grows by one on each clock edge at which it stays valid and is not granted, and it saturates at 2^AGE_W-1 (63 by default) instead of wrapping.
- R7: In open-page mode (`closed_page`=0) a grant records its row as open in its bank, and a later grant to the same bank and row reports `gnt_hit`=1.
- R8: In closed-page mode (`closed_page`=1) every grant asserts `gnt_autopre`, and the bank is then recorded as closed, so the next request to that bank reports `gnt_hit`=0.
- R9: `gnt_slot` is one-hot or zero. The granted slot is freed on the same edge. `in_ready` is 1 exactly when some slot is empty, and an accepted request goes into the lowest-index empty slot.
- R10: The age cap resets to CAP_RST (16 by default). It takes `cap_wdata` on an edge where `cap_we` is 1, and the new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New request present |
| in_ready | output | 1 | A buffer slot is free |
| in_write | input | 1 | 1 = write, 0 = read |
| in_bank | input | BANK_W | Target bank |
| in_row | input | ROW_W | Target row |
| in_qos | input | QOS_W | QoS level; larger is more urgent |
| bank_ready | input | NBANK | Per-bank timing-met flags |
| closed_page | input | 1 | Page policy: 0 open, 1 closed |
| cap_we | input | 1 | Write strobe for the age cap |
| cap_wdata | input | AGE_W | New age cap value |
| gnt_valid | output | 1 | A request is granted this cycle |
| gnt_slot | output | DEPTH | One-hot granted slot |
| gnt_write | output | 1 | Type of the granted request |
| gnt_bank | output | BANK_W | Bank of the granted request |
| gnt_row | output | ROW_W | Row of the granted request |
| gnt_qos | output | QOS_W | QoS level of the granted request |
| gnt_hit | output | 1 | Granted request hits the open row |
| gnt_autopre | output | 1 | Precharge after this access |

## Verification
The bench goes after the points where the priority terms conflict. It pits an older miss against a younger hit, a hit against a higher QoS level, and a capped miss against an urgent hit. A wrong key order would grant the other entry in each case. Two entries are left to wait until both saturate. A counter that wraps instead of saturating would drop the older entry below the cap and hand the grant to the wrong slot. Other cases repeat an access to the same row under closed-page mode, where a bank record that is not cleared would report a false hit. They also fill the buffer completely, where a slot that is not freed on the grant edge would leave `in_ready` low.

// File: rtl/fr_sched_pkg.sv
package fr_sched_pkg;
    localparam int unsigned SCHED_DEPTH   = 8;
    localparam int unsigned SCHED_NBANK   = 4;
    localparam int unsigned SCHED_ROW_W   = 14;
    localparam int unsigned SCHED_QOS_W   = 2;
    localparam int unsigned SCHED_AGE_W   = 6;
    localparam int unsigned SCHED_CAP_RST = 16;

    typedef enum logic {
        PAGE_OPEN   = 1'b0,
        PAGE_CLOSED = 1'b1
    } page_mode_e;
endpackage

// File: rtl/sched_buf.sv
module sched_buf #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned ROW_W = 14,
    parameter int unsigned QOS_W = 2,
    parameter int unsigned AGE_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_write,
    input  logic [BANK_W-1:0]               wr_bank,
    input  logic [ROW_W-1:0]                wr_row,
    input  logic [QOS_W-1:0]                wr_qos,
    input  logic [DEPTH-1:0]                clr_vec,
    output logic                            has_free,
    output logic [DEPTH-1:0]                ent_vld,
    output logic [DEPTH-1:0]                ent_wr,
    output logic [DEPTH-1:0][BANK_W-1:0]    ent_bank,
    output logic [DEPTH-1:0][ROW_W-1:0]     ent_row,
    output logic [DEPTH-1:0][QOS_W-1:0]     ent_qos,
    output logic [DEPTH-1:0][AGE_W-1:0]     ent_age
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0]             wr;
        logic [DEPTH-1:0][BANK_W-1:0] bank;
        logic [DEPTH-1:0][ROW_W-1:0]  row;
        logic [DEPTH-1:0][QOS_W-1:0]  qos;
        logic [DEPTH-1:0][AGE_W-1:0]  age;
    } buf_t;

    buf_t buf_d, buf_q;
    logic [DEPTH-1:0] ins_onehot;

    always_comb begin
        ins_onehot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!buf_q.vld[i]) begin
                ins_onehot    = '0;
                ins_onehot[i] = 1'b1;
            end
        end
    end

    always_comb begin
        buf_d = buf_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (buf_q.vld[i]) begin
                if (clr_vec[i]) begin
                    buf_d.vld[i] = 1'b0;
                end else if (buf_q.age[i] != AGE_MAX) begin
                    buf_d.age[i] = buf_q.age[i] + 1'b1;
                end
            end
            if (wr_en && ins_onehot[i]) begin
                buf_d.vld[i]  = 1'b1;
                buf_d.wr[i]   = wr_write;
                buf_d.bank[i] = wr_bank;
                buf_d.row[i]  = wr_row;
                buf_d.qos[i]  = wr_qos;
                buf_d.age[i]  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign has_free = |ins_onehot;
    assign ent_vld  = buf_q.vld;
    assign ent_wr   = buf_q.wr;
    assign ent_bank = buf_q.bank;
    assign ent_row  = buf_q.row;
    assign ent_qos  = buf_q.qos;
    assign ent_age  = buf_q.age;
endmodule

// File: rtl/sched_bank.sv
module sched_bank #(
    parameter int unsigned NBANK = 4,
    parameter int unsigned ROW_W = 14,
    parameter int unsigned AGE_W = 6,
    parameter int unsigned CAP_RST = 16,
    localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          upd_en,
    input  logic [BANK_W-1:0]             upd_bank,
    input  logic [ROW_W-1:0]              upd_row,
    input  fr_sched_pkg::page_mode_e      mode,
    input  logic                          cap_we,
    input  logic [AGE_W-1:0]              cap_wdata,
    output logic [NBANK-1:0]              open_vld,
    output logic [NBANK-1:0][ROW_W-1:0]   open_row,
    output logic [AGE_W-1:0]              age_cap
);
    typedef struct packed {
        logic [NBANK-1:0]            opn;
        logic [NBANK-1:0][ROW_W-1:0] row;
        logic [AGE_W-1:0]            cap;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (upd_en) begin
            bk_d.opn[upd_bank] = (mode == fr_sched_pkg::PAGE_OPEN);
            bk_d.row[upd_bank] = upd_row;
        end
        if (cap_we) bk_d.cap = cap_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q     <= '0;
            bk_q.cap <= AGE_W'(CAP_RST);
        end else begin
            bk_q <= bk_d;
        end
    end

    assign open_vld = bk_q.opn;
    assign open_row = bk_q.row;
    assign age_cap  = bk_q.cap;
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned NBANK = 4,
    parameter int unsigned ROW_W = 14,
    parameter int unsigned QOS_W = 2,
    parameter int unsigned AGE_W = 6,
    localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]                ent_vld,
    input  logic [DEPTH-1:0][BANK_W-1:0]    ent_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]     ent_row,
    input  logic [DEPTH-1:0][QOS_W-1:0]     ent_qos,
    input  logic [DEPTH-1:0][AGE_W-1:0]     ent_age,
    input  logic [NBANK-1:0]                bank_ready,
    input  logic [NBANK-1:0]                open_vld,
    input  logic [NBANK-1:0][ROW_W-1:0]     open_row,
    input  logic [AGE_W-1:0]                age_cap,
    output logic                            pick_vld,
    output logic [DEPTH-1:0]                pick_onehot,
    output logic [IDX_W-1:0]                pick_idx,
    output logic                            pick_hit
);
    localparam int unsigned KEY_W = 1 + QOS_W + 1 + AGE_W;

    logic [DEPTH-1:0]            elig;
    logic [DEPTH-1:0]            hit;
    logic [DEPTH-1:0][KEY_W-1:0] key;

    for (genvar g = 0; g < DEPTH; g++) begin : g_key
        logic starved;
        assign hit[g]     = open_vld[ent_bank[g]] && (open_row[ent_bank[g]] == ent_row[g]);
        assign starved    = (ent_age[g] >= age_cap);
        assign elig[g]    = ent_vld[g] && bank_ready[ent_bank[g]];
        assign key[g]     = {starved, ent_qos[g], hit[g], ent_age[g]};
    end

    always_comb begin
        logic [KEY_W-1:0] best;
        best        = '0;
        pick_vld    = 1'b0;
        pick_idx    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && (!pick_vld || key[i] > best)) begin
                pick_vld = 1'b1;
                pick_idx = IDX_W'(i);
                best     = key[i];
            end
        end
        pick_onehot           = '0;
        pick_onehot[pick_idx] = pick_vld;
        pick_hit              = pick_vld && hit[pick_idx];
    end
endmodule

// File: rtl/fr_sched.sv
module fr_sched #(
    parameter int unsigned DEPTH   = fr_sched_pkg::SCHED_DEPTH,
    parameter int unsigned NBANK   = fr_sched_pkg::SCHED_NBANK,
    parameter int unsigned ROW_W   = fr_sched_pkg::SCHED_ROW_W,
    parameter int unsigned QOS_W   = fr_sched_pkg::SCHED_QOS_W,
    parameter int unsigned AGE_W   = fr_sched_pkg::SCHED_AGE_W,
    parameter int unsigned CAP_RST = fr_sched_pkg::SCHED_CAP_RST,
    localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_write,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [QOS_W-1:0]  in_qos,
    input  logic [NBANK-1:0]  bank_ready,
    input  logic              closed_page,
    input  logic              cap_we,
    input  logic [AGE_W-1:0]  cap_wdata,
    output logic              gnt_valid,
    output logic [DEPTH-1:0]  gnt_slot,
    output logic              gnt_write,
    output logic [BANK_W-1:0] gnt_bank,
    output logic [ROW_W-1:0]  gnt_row,
    output logic [QOS_W-1:0]  gnt_qos,
    output logic              gnt_hit,
    output logic              gnt_autopre
);
    logic [DEPTH-1:0]             ent_vld, ent_wr;
    logic [DEPTH-1:0][BANK_W-1:0] ent_bank;
    logic [DEPTH-1:0][ROW_W-1:0]  ent_row;
    logic [DEPTH-1:0][QOS_W-1:0]  ent_qos;
    logic [DEPTH-1:0][AGE_W-1:0]  ent_age;
    logic [NBANK-1:0]             open_vld;
    logic [NBANK-1:0][ROW_W-1:0]  open_row;
    logic [AGE_W-1:0]             age_cap;
    logic [IDX_W-1:0]             pick_idx;
    fr_sched_pkg::page_mode_e     mode;

    assign mode = closed_page ? fr_sched_pkg::PAGE_CLOSED : fr_sched_pkg::PAGE_OPEN;

    sched_buf #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .QOS_W(QOS_W), .AGE_W(AGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(in_valid), .wr_write(in_write), .wr_bank(in_bank), .wr_row(in_row), .wr_qos(in_qos),
        .clr_vec(gnt_slot), .has_free(in_ready),
        .ent_vld(ent_vld), .ent_wr(ent_wr), .ent_bank(ent_bank), .ent_row(ent_row),
        .ent_qos(ent_qos), .ent_age(ent_age)
    );

    sched_pick #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .QOS_W(QOS_W), .AGE_W(AGE_W)) u_pick (
        .ent_vld(ent_vld), .ent_bank(ent_bank), .ent_row(ent_row), .ent_qos(ent_qos), .ent_age(ent_age),
        .bank_ready(bank_ready), .open_vld(open_vld), .open_row(open_row), .age_cap(age_cap),
        .pick_vld(gnt_valid), .pick_onehot(gnt_slot), .pick_idx(pick_idx), .pick_hit(gnt_hit)
    );

    sched_bank #(.NBANK(NBANK), .ROW_W(ROW_W), .AGE_W(AGE_W), .CAP_RST(CAP_RST)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .upd_en(gnt_valid), .upd_bank(gnt_bank), .upd_row(gnt_row), .mode(mode),
        .cap_we(cap_we), .cap_wdata(cap_wdata),
        .open_vld(open_vld), .open_row(open_row), .age_cap(age_cap)
    );

    assign gnt_write   = ent_wr[pick_idx];
    assign gnt_bank    = ent_bank[pick_idx];
    assign gnt_row     = ent_row[pick_idx];
    assign gnt_qos     = ent_qos[pick_idx];
    assign gnt_autopre = gnt_valid && (mode == fr_sched_pkg::PAGE_CLOSED);
endmodule

// File: rtl/fr_sched_chk.sv
module fr_sched_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned NBANK = 4,
    parameter int unsigned ROW_W = 14,
    parameter int unsigned BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [NBANK-1:0]  bank_ready,
    input logic              closed_page,
    input logic              gnt_valid,
    input logic [DEPTH-1:0]  gnt_slot,
    input logic [BANK_W-1:0] gnt_bank,
    input logic [ROW_W-1:0]  gnt_row,
    input logic              gnt_hit,
    input logic              gnt_autopre
);
    logic              prev_open_q, prev_closed_q;
    logic [BANK_W-1:0] prev_bank_q;
    logic [ROW_W-1:0]  prev_row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_open_q   <= 1'b0;
            prev_closed_q <= 1'b0;
            prev_bank_q   <= '0;
            prev_row_q    <= '0;
        end else begin
            prev_open_q   <= gnt_valid && !closed_page;
            prev_closed_q <= gnt_valid && closed_page;
            prev_bank_q   <= gnt_bank;
            prev_row_q    <= gnt_row;
        end
    end

    p_slot_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_slot) && (gnt_valid == (gnt_slot != '0)));

    p_bank_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> bank_ready[gnt_bank]);

    p_free_after_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> in_ready);

    p_autopre_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && closed_page) |-> gnt_autopre);

    p_closed_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && prev_closed_q && gnt_bank == prev_bank_q) |-> !gnt_hit);

    p_open_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && prev_open_q && gnt_bank == prev_bank_q && gnt_row == prev_row_q) |-> gnt_hit);
endmodule

bind fr_sched fr_sched_chk #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .bank_ready(bank_ready), .closed_page(closed_page),
    .gnt_valid(gnt_valid), .gnt_slot(gnt_slot), .gnt_bank(gnt_bank), .gnt_row(gnt_row),
    .gnt_hit(gnt_hit), .gnt_autopre(gnt_autopre)
);

// File: tb/fr_sched_bench.sv
module fr_sched_bench;
    localparam int CLK_NS = 10;
    localparam int D = 8, NB = 4, RW = 14, QW = 2, AW = 6, CAP0 = 16;
    localparam int AMAX = (1 << AW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_write = 0, closed_page = 0, cap_we = 0;
    logic [1:0] in_bank = '0;
    logic [RW-1:0] in_row = '0;
    logic [QW-1:0] in_qos = '0;
    logic [NB-1:0] bank_ready = '0;
    logic [AW-1:0] cap_wdata = '0;
    logic in_ready, gnt_valid, gnt_write, gnt_hit, gnt_autopre;
    logic [D-1:0] gnt_slot;
    logic [1:0] gnt_bank;
    logic [RW-1:0] gnt_row;
    logic [QW-1:0] gnt_qos;

    always #(CLK_NS/2) clk = ~clk;

    fr_sched u_fr_sched (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write),
        .in_bank(in_bank), .in_row(in_row), .in_qos(in_qos), .bank_ready(bank_ready),
        .closed_page(closed_page), .cap_we(cap_we), .cap_wdata(cap_wdata),
        .gnt_valid(gnt_valid), .gnt_slot(gnt_slot), .gnt_write(gnt_write), .gnt_bank(gnt_bank),
        .gnt_row(gnt_row), .gnt_qos(gnt_qos), .gnt_hit(gnt_hit), .gnt_autopre(gnt_autopre)
    );

    int n_chk = 0, n_bad = 0;
    bit m_v[D], m_w[D];
    int m_b[D], m_r[D], m_q[D], m_a[D];
    bit m_open[NB];
    int m_orow[NB];
    int m_cap;
    int obs_slot;
    bit obs_hit, obs_pre, obs_rdy;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit m_hit(int i);
        return m_open[m_b[i]] && m_orow[m_b[i]] == m_r[i];
    endfunction

    function automatic int m_pick();
        int best = -1;
        longint bk = 0;
        for (int i = 0; i < D; i++) begin
            if (m_v[i] && bank_ready[m_b[i]]) begin
                longint k = ((m_a[i] >= m_cap) ? 1 : 0) * 4096 + m_q[i] * 256
                          + (m_hit(i) ? 128 : 0) + m_a[i];
                if (best < 0 || k > bk) begin best = i; bk = k; end
            end
        end
        return best;
    endfunction

    function automatic int m_free();
        for (int i = 0; i < D; i++) if (!m_v[i]) return i;
        return -1;
    endfunction

    task automatic step();
        int p, f;
        logic [D-1:0] exp_slot;
        #(CLK_NS/4);
        p = m_pick();
        f = m_free();
        exp_slot = (p >= 0) ? (D'(1) << p) : '0;
        chk(gnt_valid == (p >= 0), "R1 gnt_valid", gnt_valid, p >= 0);
        chk(gnt_slot == exp_slot, "R9 gnt_slot", gnt_slot, exp_slot);
        chk(in_ready == (f >= 0), "R9 in_ready", in_ready, f >= 0);
        if (p >= 0) begin
            chk(gnt_hit == m_hit(p), "R2 gnt_hit", gnt_hit, m_hit(p));
            chk(gnt_autopre == closed_page, "R8 gnt_autopre", gnt_autopre, closed_page);
            chk(gnt_bank == m_b[p] && gnt_row == m_r[p] && gnt_qos == m_q[p] && gnt_write == m_w[p],
                "R9 gnt fields", gnt_row, m_r[p]);
        end
        obs_slot = -1;
        for (int i = 0; i < D; i++) if (gnt_slot[i]) obs_slot = i;
        obs_hit = gnt_hit; obs_pre = gnt_autopre; obs_rdy = in_ready;
        @(posedge clk);
        for (int i = 0; i < D; i++) begin
            if (m_v[i] && i != p && m_a[i] < AMAX) m_a[i]++;
        end
        if (p >= 0) begin
            m_v[p] = 0;
            m_open[m_b[p]] = !closed_page;
            m_orow[m_b[p]] = m_r[p];
        end
        if (in_valid && f >= 0) begin
            m_v[f] = 1; m_w[f] = in_write; m_b[f] = in_bank; m_r[f] = in_row; m_q[f] = in_qos; m_a[f] = 0;
        end
        if (cap_we) m_cap = cap_wdata;
        @(negedge clk);
        in_valid = 0; cap_we = 0;
    endtask

    task automatic push(int b, int r, int q);
        in_valid = 1; in_write = q[0]; in_bank = 2'(b); in_row = RW'(r); in_qos = QW'(q);
        bank_ready = '0;
        step();
    endtask

    task automatic idle(int n);
        bank_ready = '0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic serve(logic [NB-1:0] rdy);
        bank_ready = rdy;
        step();
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_cap = CAP0;
        for (int i = 0; i < D; i++) begin m_v[i] = 0; m_a[i] = 0; end
        for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_orow[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1/R9: reset state
        #(CLK_NS/4);
        chk(gnt_valid == 0 && gnt_slot == '0, "R1 reset no grant", gnt_slot, 0);
        chk(in_ready == 1, "R9 reset in_ready", in_ready, 1);
        @(negedge clk);

        // R1: first access, bank 0 row 5
        push(0, 5, 0);
        serve(4'b0001);
        chk(obs_slot == 0 && obs_hit == 0, "R1 first grant", obs_slot, 0);

        // R2/R7: younger hit beats older miss
        push(0, 9, 0);
        push(0, 5, 0);
        serve(4'b0001);
        chk(obs_slot == 1 && obs_hit == 1, "R2 hit beats older miss", obs_slot, 1);
        serve(4'b0001);
        chk(obs_slot == 0 && obs_hit == 0, "R7 row 5 still open, row 9 misses", obs_hit, 0);

        // R1/R3: bank not ready blocks; older wins among misses
        push(2, 3, 0);
        push(1, 4, 0);
        serve(4'b0010);
        chk(obs_slot == 1, "R1 only ready bank granted", obs_slot, 1);
        serve(4'b0110);
        chk(obs_slot == 0, "R3 remaining entry", obs_slot, 0);
        push(2, 8, 0);
        push(1, 6, 0);
        serve(4'b0110);
        chk(obs_slot == 0, "R3 older miss wins", obs_slot, 0);
        serve(4'b0110);

        // R4: higher QoS beats row hit
        push(3, 7, 0);
        serve(4'b1000);
        push(3, 7, 0);
        push(3, 8, 2);
        serve(4'b1000);
        chk(obs_slot == 1 && obs_hit == 0, "R4 qos beats hit", obs_slot, 1);
        serve(4'b1000);

        // R10/R5: cap set to 3, capped miss beats urgent hit
        cap_we = 1; cap_wdata = 3;
        push(0, 1, 0);
        idle(3);
        push(0, 9, 3);
        serve(4'b0001);
        chk(obs_slot == 0 && obs_hit == 0, "R5 capped miss beats qos hit", obs_slot, 0);
        serve(4'b0001);
        chk(obs_slot == 1, "R10 cap write applied", obs_slot, 1);

        // R8: closed page
        closed_page = 1;
        push(2, 8, 0);
        serve(4'b0100);
        chk(obs_hit == 1 && obs_pre == 1, "R8 autopre on hit", obs_pre, 1);
        push(2, 8, 0);
        serve(4'b0100);
        chk(obs_hit == 0 && obs_pre == 1, "R8 bank closed after access", obs_hit, 0);
        closed_page = 0;

        // R6/R3: saturation makes a tie, lowest index wins
        push(1, 11, 0);
        push(1, 12, 0);
        idle(AMAX);
        serve(4'b0010);
        chk(obs_slot == 0, "R6 saturated tie to slot 0", obs_slot, 0);
        serve(4'b0010);

        // R9: full buffer, then slot freed by a grant
        for (int i = 0; i < D; i++) push(3, i, 1);
        bank_ready = '0;
        step();
        chk(obs_rdy == 0, "R9 full buffer not ready", obs_rdy, 0);
        serve(4'b1000);
        idle(1);
        chk(obs_rdy == 1, "R9 ready after grant frees slot", obs_rdy, 1);
        for (int i = 0; i < D; i++) serve(4'b1000);

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            in_valid = ($urandom_range(0, 3) != 0);
            in_write = 1'($urandom);
            in_bank = 2'($urandom);
            in_row = RW'($urandom_range(0, 3));
            in_qos = QW'($urandom_range(0, 7) == 0 ? $urandom : 0);
            bank_ready = NB'($urandom);
            if ($urandom_range(0, 99) == 0) closed_page = ~closed_page;
            if ($urandom_range(0, 149) == 0) begin cap_we = 1; cap_wdata = AW'($urandom_range(2, 40)); end
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule